// File: doc/BRIEF.md
# Keyboard Command Receiver with Coded Acknowledge

This block sits on the keyboard side of a host link and takes in short commands sent by the host. A command is four serial bits: three data bits and then one parity bit. Each bit is presented on a positive-logic data line and is marked by an active-low strobe from the host. Both host lines are asynchronous to the block clock. They pass through synchronizers, and each bit is taken on a detected falling edge of the strobe.

After the parity bit, the block answers on its own two outgoing lines. The shape of that answer carries the outcome. When the command was taken, the keyboard strobe and keyboard data lines pulse high together. When it was refused, only the keyboard strobe pulses. The host resends after a strobe-only answer. The pulse starts a programmable number of cycles after the parity bit and lasts a programmable number of cycles.

An accepted command is handed to local logic on a valid/ready output. The code is held with `cmd_valid` high until a cycle in which `cmd_ready` is also high. While that output holds an untaken code, it exerts back-pressure: a further frame with good parity is refused and gets the strobe-only answer, so the host retries it later. A frame left half-sent is dropped once the strobe has been idle for a gap timeout.

Top module: `kbc_cmd_rx`

## Requirements
- R1: After reset, `kb_stb`, `kb_data` and `cmd_valid` are low.
- R2: A frame is four falling edges of `host_stb_n`, with `host_data` high meaning 1. The first three bits are code bits 0, 1 and 2, in that order, and the fourth bit is parity.
- R3: A frame with an odd count of ones across all four bits has good parity. When the output is free, such a frame raises `cmd_valid` with `cmd_code` equal to its three data bits.
- R4: A frame with an even count of ones produces no `cmd_valid`. Its answer is a pulse on `kb_stb` with `kb_data` held low.
- R5: An accepted frame is answered by `kb_stb` and `kb_data` high together for exactly ACK_WIDTH_CYC cycles. `kb_data` is never high while `kb_stb` is low.
- R6: The answer pulse begins between ACK_DELAY_CYC and ACK_DELAY_CYC+SYNC_STAGES+3 cycles after the falling strobe edge of the parity bit.
- R7: If the strobe stays idle for GAP_CYC cycles after a partial frame, the bits already received are discarded. The next strobe edge is then taken as code bit 0.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and `cmd_code` stay unchanged. A good-parity frame that ends in this state is refused and gets the strobe-only answer.
- R9: Strobe edges that arrive between the end of a frame and the end of its answer pulse are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_stb_n | input | 1 | Host bit strobe, active low, asynchronous |
| host_data | input | 1 | Host serial data, positive logic, asynchronous |
| kb_stb | output | 1 | Keyboard answer strobe, active high |
| kb_data | output | 1 | Keyboard answer data; pulses with `kb_stb` only for an accepted frame |
| cmd_valid | output | 1 | Command code available |
| cmd_ready | input | 1 | Local logic takes the code in a cycle where `cmd_valid` is also high |
| cmd_code | output | DATA_BITS | Received command code |

## Verification
The bench sends all eight codes with correct parity, so a design that reversed the bit order or mixed up the sense of parity delivers the wrong codes to the scoreboard. It then sends frames with parity flipped: a design that still answered with data, or still raised `cmd_valid`, is caught by the answer-shape check or by the scoreboard.

The pulse is timed from the parity edge and its width is counted cycle by cycle, so an off-by-one delay or width counter fails. A half-sent frame followed by a long pause checks the gap timeout; without it, the next frame would be misaligned and answered too early. Strobes thrown into the answer window would form an extra valid command if they were not ignored. A stalled output, with a second frame arriving, checks that the held code does not change and that the second frame is refused.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE  = 2'd0,
    ACK_WAIT  = 2'd1,
    ACK_PULSE = 2'd2
  } ack_state_e;
endpackage

// File: rtl/kbc_sync.sv
module kbc_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_async,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= RST_VAL;
        else        chain <= din_async;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din_async};
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/kbc_frame.sv
module kbc_frame #(
  parameter int DATA_BITS = 3,
  parameter int GAP_CYC   = 5000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb_s,
  input  logic                 dat_s,
  input  logic                 hold,
  output logic                 frame_done,
  output logic [DATA_BITS-1:0] frame_data,
  output logic                 parity_ok
);
  localparam int BCW = $clog2(DATA_BITS + 1);
  localparam int GCW = $clog2(GAP_CYC + 1);

  logic                 stb_prev;
  logic                 fall;
  logic [BCW-1:0]       bit_cnt;
  logic [GCW-1:0]       gap_cnt;
  logic [DATA_BITS-1:0] shreg;

  assign fall = stb_prev & ~stb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev   <= 1'b1;
      bit_cnt    <= '0;
      gap_cnt    <= '0;
      shreg      <= '0;
      frame_done <= 1'b0;
      frame_data <= '0;
      parity_ok  <= 1'b0;
    end else begin
      stb_prev   <= stb_s;
      frame_done <= 1'b0;
      if (fall && !hold) begin
        gap_cnt <= '0;
        if (bit_cnt == BCW'(DATA_BITS)) begin
          frame_done <= 1'b1;
          frame_data <= shreg;
          parity_ok  <= ^{dat_s, shreg};
          bit_cnt    <= '0;
        end else begin
          shreg   <= {dat_s, shreg[DATA_BITS-1:1]};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (bit_cnt != '0) begin
        if (gap_cnt == GCW'(GAP_CYC - 1)) begin
          bit_cnt <= '0;
          gap_cnt <= '0;
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
      end
    end
  end

  assert_gap_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt != '0 && gap_cnt == GCW'(GAP_CYC - 1) && !(fall && !hold)) |=> bit_cnt == '0);
endmodule

// File: rtl/kbc_ack.sv
module kbc_ack
  import kbc_pkg::*;
#(
  parameter int DELAY_CYC = 1875,
  parameter int WIDTH_CYC = 4375
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic good,
  output logic ack_stb,
  output logic ack_dat,
  output logic busy
);
  localparam int MAXC = (DELAY_CYC > WIDTH_CYC) ? DELAY_CYC : WIDTH_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  ack_state_e    state;
  logic [CW-1:0] cnt;
  logic          good_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ACK_IDLE;
      cnt    <= '0;
      good_q <= 1'b0;
    end else begin
      unique case (state)
        ACK_IDLE: if (start) begin
          state  <= ACK_WAIT;
          cnt    <= CW'(DELAY_CYC - 1);
          good_q <= good;
        end
        ACK_WAIT: if (cnt == '0) begin
          state <= ACK_PULSE;
          cnt   <= CW'(WIDTH_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        ACK_PULSE: if (cnt == '0) begin
          state <= ACK_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: state <= ACK_IDLE;
      endcase
    end
  end

  assign ack_stb = (state == ACK_PULSE);
  assign ack_dat = ack_stb & good_q;
  assign busy    = (state != ACK_IDLE);

  assert_data_needs_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_dat |-> ack_stb);
  assert_start_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> state == ACK_IDLE);
endmodule

// File: rtl/kbc_cmd_rx.sv
module kbc_cmd_rx #(
  parameter int DATA_BITS     = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int ACK_DELAY_CYC = 1875,
  parameter int ACK_WIDTH_CYC = 4375,
  parameter int GAP_CYC       = 5000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_stb_n,
  input  logic                 host_data,
  output logic                 kb_stb,
  output logic                 kb_data,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [DATA_BITS-1:0] cmd_code
);
  logic                 stb_s, dat_s;
  logic                 frame_done, parity_ok, busy;
  logic [DATA_BITS-1:0] frame_data;
  logic                 slot_free, take;

  kbc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_stb (
    .clk(clk), .rst_n(rst_n), .din_async(host_stb_n), .dout(stb_s));
  kbc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .din_async(host_data), .dout(dat_s));

  kbc_frame #(.DATA_BITS(DATA_BITS), .GAP_CYC(GAP_CYC)) u_frame (
    .clk(clk), .rst_n(rst_n), .stb_s(stb_s), .dat_s(dat_s), .hold(busy),
    .frame_done(frame_done), .frame_data(frame_data), .parity_ok(parity_ok));

  assign slot_free = !cmd_valid || cmd_ready;
  assign take      = frame_done && parity_ok && slot_free;

  kbc_ack #(.DELAY_CYC(ACK_DELAY_CYC), .WIDTH_CYC(ACK_WIDTH_CYC)) u_ack (
    .clk(clk), .rst_n(rst_n), .start(frame_done), .good(take),
    .ack_stb(kb_stb), .ack_dat(kb_data), .busy(busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
    end else if (take) begin
      cmd_valid <= 1'b1;
      cmd_code  <= frame_data;
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code)));
  assert_valid_from_good_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(frame_done && parity_ok));
  assert_data_rises_with_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kb_data) |-> $rose(kb_stb));
  assert_no_frame_in_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !frame_done);
endmodule

// File: tb/sim_kbc_cmd_rx.sv
module sim_kbc_cmd_rx;
  localparam int DB = 3, SY = 2, DLY = 20, WID = 30, GAP = 100;

  logic clk = 0, rst_n = 0, host_stb_n = 1, host_data = 0, cmd_ready = 1;
  logic kb_stb, kb_data, cmd_valid;
  logic [DB-1:0] cmd_code;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [DB-1:0] expq[$];

  always #2 clk = ~clk;

  kbc_cmd_rx #(.DATA_BITS(DB), .SYNC_STAGES(SY), .ACK_DELAY_CYC(DLY),
               .ACK_WIDTH_CYC(WID), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .host_stb_n(host_stb_n), .host_data(host_data),
    .kb_stb(kb_stb), .kb_data(kb_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_code(cmd_code));

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard on each handshake
  always @(negedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      if (expq.size() == 0) check(0, "R3 unexpected command", int'(cmd_code), -1);
      else begin
        logic [DB-1:0] e;
        e = expq.pop_front();
        check(cmd_code == e, "R2/R3 command code", int'(cmd_code), int'(e));
      end
    end
  end

  task automatic strobe_bit(bit b);
    host_data = b;
    repeat (2) @(negedge clk);
    host_stb_n = 0;
    repeat (4) @(negedge clk);
    host_stb_n = 1;
    repeat (4) @(negedge clk);
  endtask

  // sends one frame and checks the answer; accept = output slot expected free
  task automatic send_frame(logic [DB-1:0] code, bit bad_par, bit accept);
    bit par, good;
    int cyc, w, derr;
    par  = ~(^code) ^ bad_par;
    good = !bad_par && accept;
    for (int i = 0; i < DB; i++) strobe_bit(code[i]);
    if (good) expq.push_back(code);
    host_data = par;
    repeat (2) @(negedge clk);
    host_stb_n = 0;
    cyc = 0;
    while (!kb_stb && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (cyc == 4) host_stb_n = 1;
    end
    host_stb_n = 1;
    check(cyc >= DLY && cyc <= DLY + SY + 3, "R6 answer latency", cyc, DLY);
    w = 0; derr = 0;
    while (kb_stb && w < 400) begin
      if (kb_data != good) derr++;
      @(negedge clk);
      w++;
    end
    check(w == WID, "R5 answer width", w, WID);
    check(derr == 0, good ? "R5 data pulses with strobe" : "R4 strobe-only answer",
          derr, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(kb_stb == 0, "R1 kb_stb reset", kb_stb, 0);
    check(kb_data == 0, "R1 kb_data reset", kb_data, 0);
    check(cmd_valid == 0, "R1 cmd_valid reset", cmd_valid, 0);

    // R2 R3: all codes, good parity
    for (int c = 0; c < 8; c++) send_frame(DB'(c), 0, 1);

    // R4: bad parity
    send_frame(3'b101, 1, 1);
    check(cmd_valid == 0, "R4 no valid on bad parity", cmd_valid, 0);
    send_frame(3'b000, 1, 1);
    check(cmd_valid == 0, "R4 no valid on bad parity", cmd_valid, 0);

    // R7: partial frame then idle gap
    strobe_bit(1);
    strobe_bit(1);
    repeat (GAP + 20) @(negedge clk);
    check(kb_stb == 0, "R7 no answer for partial frame", kb_stb, 0);
    send_frame(3'b010, 0, 1);

    // R8: back-pressure
    cmd_ready = 0;
    send_frame(3'b110, 0, 1);
    send_frame(3'b011, 0, 0);
    check(cmd_valid == 1, "R8 valid held", cmd_valid, 1);
    check(cmd_code == 3'b110, "R8 code held", int'(cmd_code), 6);
    cmd_ready = 1;
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R8 held code delivered", expq.size(), 0);
    check(cmd_valid == 0, "R8 valid drops after take", cmd_valid, 0);

    // R9: strobes during answer window ignored
    for (int i = 0; i < DB; i++) strobe_bit(i == 0);
    expq.push_back(3'b001);
    host_data = 0;
    repeat (2) @(negedge clk);
    host_stb_n = 0;
    repeat (4) @(negedge clk);
    host_stb_n = 1;
    for (int j = 0; j < 4; j++) begin
      host_data = (j == 0);
      @(negedge clk);
      host_stb_n = 0;
      repeat (3) @(negedge clk);
      host_stb_n = 1;
      repeat (3) @(negedge clk);
    end
    repeat (80) @(negedge clk);
    check(expq.size() == 0, "R9 one command from window", expq.size(), 0);
    check(cmd_valid == 0, "R9 no extra command", cmd_valid, 0);
    send_frame(3'b100, 0, 1);

    repeat (5) @(negedge clk);
    check(expq.size() == 0, "R3 scoreboard drained", expq.size(), 0);
    finish_run();
  end
endmodule